// File: doc/BRIEF.md
# Two-Level Branch Address Cache Lookup

This block stores, for each fetch block, a small tree of start addresses for the basic blocks that follow it. One fetch address is looked up per cycle. With two predicted branch outcomes presented alongside that address, the block returns up to two further fetch addresses in one response. This lets a wide front end use two branch predictions per cycle without a second lookup.

Each entry is direct-mapped and holds the following fields:
- a tag;
- a primary branch valid bit and kind, with the primary taken and not-taken addresses;
- valid bits and kinds for a secondary branch on each primary path;
- four second-level addresses, one for each outcome pair.

The primary outcome picks the second fetch address. The outcome pair picks the third. On a miss the block offers only the sequential next block. A fill port writes a whole entry in one cycle.

The response is registered. It appears one cycle after the request.

Top module: `bac_lookup`

## Requirements
- R1: After reset every entry is invalid and all response outputs are zero. The first lookup of any address after reset misses.
- R2: A lookup request (`fetch_vld` high) produces a response with `rsp_vld` high in the next cycle. A cycle without a request is followed by a cycle with `rsp_vld`, `rsp_hit` and `rsp_addr3_vld` low.
- R3: On a miss, `rsp_hit` is 0 and `rsp_addr2` equals `fetch_pc + BLOCK_BYTES`. In the same response `rsp_addr3_vld` is 0 and `rsp_addr3` is 0.
- R4: A hit needs a valid entry at the index whose stored tag matches. The index is `fetch_pc` bits `[log2(BLOCK_BYTES) +: log2(ENTRIES)]` and the tag is every bit above it. An address with the same index and a different tag misses.
- R5: On a hit with the primary valid bit set, `rsp_addr2` is the stored taken address when `pred_p_tk` is 1. It is the stored not-taken address when `pred_p_tk` is 0.
- R6: On a hit where the secondary branch on the chosen path is valid, `rsp_addr3_vld` is 1. `rsp_addr3` is the second-level address picked by the code {`pred_p_tk`,`pred_s_tk`}: 3 taken-taken, 2 taken-not-taken, 1 not-taken-taken, 0 not-taken-not-taken.
- R7: If the secondary valid bit on the chosen primary path is clear, `rsp_addr3_vld`, `rsp_addr3` and `rsp_kind2` are all 0.
- R8: On a hit with the primary valid bit clear, `rsp_addr2` is the stored not-taken address and `rsp_addr3_vld` is 0, whatever the predictions are. `rsp_kind1` is 0 in this case.
- R9: `rsp_kind1` returns the stored 2-bit primary kind. `rsp_kind2` returns the stored 2-bit secondary kind of the chosen path. Kinds are stored verbatim.
- R10: A lookup in the same cycle as a fill to its index sees the newly written entry. A fill to a different index leaves the lookup's result unchanged.
- R11: A fill replaces the whole entry at its index. A later lookup of the address whose tag was displaced misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_vld | input | 1 | Lookup request this cycle |
| fetch_pc | input | ADDR_W | Fetch address to look up |
| pred_p_tk | input | 1 | Predicted outcome of the primary branch (1 = taken) |
| pred_s_tk | input | 1 | Predicted outcome of the secondary branch (1 = taken) |
| fill_en | input | 1 | Write a whole entry this cycle |
| fill_blk | input | ADDR_W-log2(BLOCK_BYTES) | Block address of the entry (fetch address without offset bits) |
| fill_p_vld | input | 1 | Primary branch present |
| fill_p_kind | input | 2 | Primary branch kind |
| fill_t_addr | input | ADDR_W | Primary taken address |
| fill_n_addr | input | ADDR_W | Primary not-taken address |
| fill_st_vld | input | 1 | Secondary branch present on the taken path |
| fill_st_kind | input | 2 | Kind of that branch |
| fill_sn_vld | input | 1 | Secondary branch present on the not-taken path |
| fill_sn_kind | input | 2 | Kind of that branch |
| fill_tt_addr | input | ADDR_W | Taken-taken address |
| fill_tn_addr | input | ADDR_W | Taken-not-taken address |
| fill_nt_addr | input | ADDR_W | Not-taken-taken address |
| fill_nn_addr | input | ADDR_W | Not-taken-not-taken address |
| rsp_vld | output | 1 | Response valid; `rsp_addr2` is usable |
| rsp_hit | output | 1 | Lookup hit |
| rsp_addr2 | output | ADDR_W | Second fetch address |
| rsp_addr3_vld | output | 1 | Third fetch address valid |
| rsp_addr3 | output | ADDR_W | Third fetch address |
| rsp_kind1 | output | 2 | Kind of the primary branch |
| rsp_kind2 | output | 2 | Kind of the chosen secondary branch |

## Verification
The bench builds the block with ADDR_W=32, ENTRIES=8 and BLOCK_BYTES=16. The index then takes address bits 6:4, and two addresses 128 bytes apart collide. This puts aliasing misses and eviction by refill (R4, R11) within reach of a few hand-picked addresses. The small table also lets the same-cycle fill-and-lookup cases hit both the matching and a non-matching index cheaply.

// File: rtl/bac_pkg.sv
package bac_pkg;

  // Per-entry control fields: presence and kind of each branch in the tree.
  typedef struct packed {
    logic       p_vld;
    logic [1:0] p_kind;
    logic       st_vld;
    logic [1:0] st_kind;
    logic       sn_vld;
    logic [1:0] sn_kind;
  } bac_meta_t;

  // Second-level leaf numbering; the code is {primary taken, secondary taken}.
  localparam int LEAF_NN = 0;
  localparam int LEAF_NT = 1;
  localparam int LEAF_TN = 2;
  localparam int LEAF_TT = 3;

  function automatic logic [1:0] leaf_of(input logic p_tk, input logic s_tk);
    return {p_tk, s_tk};
  endfunction

  function automatic logic sec_vld_of(input bac_meta_t m, input logic p_tk);
    return p_tk ? m.st_vld : m.sn_vld;
  endfunction

  function automatic logic [1:0] sec_kind_of(input bac_meta_t m, input logic p_tk);
    return p_tk ? m.st_kind : m.sn_kind;
  endfunction

endpackage

// File: rtl/bac_store.sv
module bac_store
  import bac_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5,
  parameter int TAG_W   = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [TAG_W-1:0]       wr_tag,
  input  bac_meta_t              wr_meta,
  input  logic [1:0][ADDR_W-1:0] wr_l1,
  input  logic [3:0][ADDR_W-1:0] wr_l2,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic                   rd_vld,
  output logic [TAG_W-1:0]       rd_tag,
  output bac_meta_t              rd_meta,
  output logic [1:0][ADDR_W-1:0] rd_l1,
  output logic [3:0][ADDR_W-1:0] rd_l2,
  output logic                   rd_fwd
);

  logic [ENTRIES-1:0]       vld_q;
  logic [TAG_W-1:0]         tag_q  [ENTRIES];
  bac_meta_t                meta_q [ENTRIES];
  logic [1:0][ADDR_W-1:0]   l1_q   [ENTRIES];
  logic [3:0][ADDR_W-1:0]   l2_q   [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      meta_q[wr_idx] <= wr_meta;
      l1_q[wr_idx]   <= wr_l1;
      l2_q[wr_idx]   <= wr_l2;
    end
  end

  // A fill to the index being read wins over the stored copy.
  assign rd_fwd = wr_en && (wr_idx == rd_idx);

  always_comb begin
    if (rd_fwd) begin
      rd_vld  = 1'b1;
      rd_tag  = wr_tag;
      rd_meta = wr_meta;
      rd_l1   = wr_l1;
      rd_l2   = wr_l2;
    end else begin
      rd_vld  = vld_q[rd_idx];
      rd_tag  = tag_q[rd_idx];
      rd_meta = meta_q[rd_idx];
      rd_l1   = l1_q[rd_idx];
      rd_l2   = l2_q[rd_idx];
    end
  end

endmodule

// File: rtl/bac_path_sel.sv
module bac_path_sel
  import bac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   hit,
  input  bac_meta_t              meta,
  input  logic [1:0][ADDR_W-1:0] l1,
  input  logic [3:0][ADDR_W-1:0] l2,
  input  logic                   p_tk,
  input  logic                   s_tk,
  input  logic [ADDR_W-1:0]      seq_pc,
  output logic [ADDR_W-1:0]      nxt2,
  output logic [ADDR_W-1:0]      nxt3,
  output logic                   nxt3_vld,
  output logic [1:0]             kind1,
  output logic [1:0]             kind2,
  output logic [1:0]             leaf
);

  logic       sec_vld;
  logic [1:0] sec_kind;

  always_comb begin
    leaf     = leaf_of(p_tk, s_tk);
    sec_vld  = sec_vld_of(meta, p_tk);
    sec_kind = sec_kind_of(meta, p_tk);
    nxt2     = seq_pc;
    nxt3     = '0;
    nxt3_vld = 1'b0;
    kind1    = 2'b00;
    kind2    = 2'b00;
    if (hit) begin
      if (meta.p_vld) begin
        nxt2  = l1[p_tk];
        kind1 = meta.p_kind;
        if (sec_vld) begin
          nxt3     = l2[leaf];
          nxt3_vld = 1'b1;
          kind2    = sec_kind;
        end
      end else begin
        nxt2 = l1[0];
      end
    end
  end

endmodule

// File: rtl/bac_lookup.sv
module bac_lookup
  import bac_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 32,
  parameter int BLOCK_BYTES = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   fetch_vld,
  input  logic [ADDR_W-1:0]                      fetch_pc,
  input  logic                                   pred_p_tk,
  input  logic                                   pred_s_tk,
  input  logic                                   fill_en,
  input  logic [ADDR_W-1:$clog2(BLOCK_BYTES)]    fill_blk,
  input  logic                                   fill_p_vld,
  input  logic [1:0]                             fill_p_kind,
  input  logic [ADDR_W-1:0]                      fill_t_addr,
  input  logic [ADDR_W-1:0]                      fill_n_addr,
  input  logic                                   fill_st_vld,
  input  logic [1:0]                             fill_st_kind,
  input  logic                                   fill_sn_vld,
  input  logic [1:0]                             fill_sn_kind,
  input  logic [ADDR_W-1:0]                      fill_tt_addr,
  input  logic [ADDR_W-1:0]                      fill_tn_addr,
  input  logic [ADDR_W-1:0]                      fill_nt_addr,
  input  logic [ADDR_W-1:0]                      fill_nn_addr,
  output logic                                   rsp_vld,
  output logic                                   rsp_hit,
  output logic [ADDR_W-1:0]                      rsp_addr2,
  output logic                                   rsp_addr3_vld,
  output logic [ADDR_W-1:0]                      rsp_addr3,
  output logic [1:0]                             rsp_kind1,
  output logic [1:0]                             rsp_kind2
);

  localparam int OFS_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(BLOCK_BYTES);
  endfunction

  // Named internal events, visible to the checker.
  logic [IDX_W-1:0]       look_idx;
  logic [TAG_W-1:0]       look_tag;
  logic [IDX_W-1:0]       fill_idx;
  logic [TAG_W-1:0]       fill_tag;
  logic                   ent_vld;
  logic [TAG_W-1:0]       ent_tag;
  bac_meta_t              ent_meta;
  logic [1:0][ADDR_W-1:0] ent_l1;
  logic [3:0][ADDR_W-1:0] ent_l2;
  logic                   fill_fwd;
  logic                   tag_match;
  logic                   lookup_hit;
  bac_meta_t              fill_meta;
  logic [1:0][ADDR_W-1:0] fill_l1;
  logic [3:0][ADDR_W-1:0] fill_l2;
  logic [ADDR_W-1:0]      sel_addr2;
  logic [ADDR_W-1:0]      sel_addr3;
  logic                   sel_addr3_vld;
  logic [1:0]             sel_kind1;
  logic [1:0]             sel_kind2;
  logic [1:0]             sel_leaf;

  assign look_idx = fetch_pc[OFS_W +: IDX_W];
  assign look_tag = fetch_pc[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_blk[OFS_W +: IDX_W];
  assign fill_tag = fill_blk[ADDR_W-1 -: TAG_W];

  assign fill_meta = '{p_vld:   fill_p_vld,  p_kind:  fill_p_kind,
                       st_vld:  fill_st_vld, st_kind: fill_st_kind,
                       sn_vld:  fill_sn_vld, sn_kind: fill_sn_kind};
  assign fill_l1   = {fill_t_addr, fill_n_addr};
  assign fill_l2   = {fill_tt_addr, fill_tn_addr, fill_nt_addr, fill_nn_addr};

  bac_store #(
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W)
  ) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (fill_en),
    .wr_idx (fill_idx),
    .wr_tag (fill_tag),
    .wr_meta(fill_meta),
    .wr_l1  (fill_l1),
    .wr_l2  (fill_l2),
    .rd_idx (look_idx),
    .rd_vld (ent_vld),
    .rd_tag (ent_tag),
    .rd_meta(ent_meta),
    .rd_l1  (ent_l1),
    .rd_l2  (ent_l2),
    .rd_fwd (fill_fwd)
  );

  assign tag_match  = (ent_tag == look_tag);
  assign lookup_hit = ent_vld && tag_match;

  bac_path_sel #(
    .ADDR_W(ADDR_W)
  ) i_path_sel (
    .hit     (lookup_hit),
    .meta    (ent_meta),
    .l1      (ent_l1),
    .l2      (ent_l2),
    .p_tk    (pred_p_tk),
    .s_tk    (pred_s_tk),
    .seq_pc  (seq_next(fetch_pc)),
    .nxt2    (sel_addr2),
    .nxt3    (sel_addr3),
    .nxt3_vld(sel_addr3_vld),
    .kind1   (sel_kind1),
    .kind2   (sel_kind2),
    .leaf    (sel_leaf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld       <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_addr2     <= '0;
      rsp_addr3_vld <= 1'b0;
      rsp_addr3     <= '0;
      rsp_kind1     <= 2'b00;
      rsp_kind2     <= 2'b00;
    end else if (fetch_vld) begin
      rsp_vld       <= 1'b1;
      rsp_hit       <= lookup_hit;
      rsp_addr2     <= sel_addr2;
      rsp_addr3_vld <= sel_addr3_vld;
      rsp_addr3     <= sel_addr3;
      rsp_kind1     <= sel_kind1;
      rsp_kind2     <= sel_kind2;
    end else begin
      rsp_vld       <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_addr2     <= '0;
      rsp_addr3_vld <= 1'b0;
      rsp_addr3     <= '0;
      rsp_kind1     <= 2'b00;
      rsp_kind2     <= 2'b00;
    end
  end

endmodule

// File: rtl/bac_lookup_chk.sv
module bac_lookup_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_vld,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              lookup_hit,
  input logic              fill_fwd,
  input logic              fill_en,
  input logic              rsp_vld,
  input logic              rsp_hit,
  input logic [ADDR_W-1:0] rsp_addr2,
  input logic              rsp_addr3_vld,
  input logic [ADDR_W-1:0] rsp_addr3,
  input logic [1:0]        rsp_kind2
);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |=> rsp_vld);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> (!rsp_vld && !rsp_hit && !rsp_addr3_vld));

  // R3
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_hit) |->
      (rsp_addr2 == ($past(fetch_pc) + ADDR_W'(BLOCK_BYTES)) && !rsp_addr3_vld));

  // R7
  third_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_addr3_vld |-> (rsp_addr3 == '0 && rsp_kind2 == 2'b00));

  // R6
  third_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr3_vld |-> (rsp_hit && rsp_vld));

  // R10
  fwd_hits_registered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && lookup_hit) |=> rsp_hit);

  // R10
  fwd_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fwd |-> fill_en);

endmodule

bind bac_lookup bac_lookup_chk #(
  .ADDR_W     (ADDR_W),
  .BLOCK_BYTES(BLOCK_BYTES)
) i_bac_lookup_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_vld    (fetch_vld),
  .fetch_pc     (fetch_pc),
  .lookup_hit   (lookup_hit),
  .fill_fwd     (fill_fwd),
  .fill_en      (fill_en),
  .rsp_vld      (rsp_vld),
  .rsp_hit      (rsp_hit),
  .rsp_addr2    (rsp_addr2),
  .rsp_addr3_vld(rsp_addr3_vld),
  .rsp_addr3    (rsp_addr3),
  .rsp_kind2    (rsp_kind2)
);

// File: tb/test_bac_lookup.sv
module test_bac_lookup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_p_tk = 1'b0;
  logic        pred_s_tk = 1'b0;
  logic        fill_en = 1'b0;
  logic [31:4] fill_blk = '0;
  logic        fill_p_vld = 1'b0;
  logic [1:0]  fill_p_kind = '0;
  logic [31:0] fill_t_addr = '0;
  logic [31:0] fill_n_addr = '0;
  logic        fill_st_vld = 1'b0;
  logic [1:0]  fill_st_kind = '0;
  logic        fill_sn_vld = 1'b0;
  logic [1:0]  fill_sn_kind = '0;
  logic [31:0] fill_tt_addr = '0;
  logic [31:0] fill_tn_addr = '0;
  logic [31:0] fill_nt_addr = '0;
  logic [31:0] fill_nn_addr = '0;
  logic        rsp_vld;
  logic        rsp_hit;
  logic [31:0] rsp_addr2;
  logic        rsp_addr3_vld;
  logic [31:0] rsp_addr3;
  logic [1:0]  rsp_kind1;
  logic [1:0]  rsp_kind2;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bac_lookup #(
    .ADDR_W     (32),
    .ENTRIES    (8),
    .BLOCK_BYTES(16)
  ) i_bac_lookup (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_vld    (fetch_vld),
    .fetch_pc     (fetch_pc),
    .pred_p_tk    (pred_p_tk),
    .pred_s_tk    (pred_s_tk),
    .fill_en      (fill_en),
    .fill_blk     (fill_blk),
    .fill_p_vld   (fill_p_vld),
    .fill_p_kind  (fill_p_kind),
    .fill_t_addr  (fill_t_addr),
    .fill_n_addr  (fill_n_addr),
    .fill_st_vld  (fill_st_vld),
    .fill_st_kind (fill_st_kind),
    .fill_sn_vld  (fill_sn_vld),
    .fill_sn_kind (fill_sn_kind),
    .fill_tt_addr (fill_tt_addr),
    .fill_tn_addr (fill_tn_addr),
    .fill_nt_addr (fill_nt_addr),
    .fill_nn_addr (fill_nn_addr),
    .rsp_vld      (rsp_vld),
    .rsp_hit      (rsp_hit),
    .rsp_addr2    (rsp_addr2),
    .rsp_addr3_vld(rsp_addr3_vld),
    .rsp_addr3    (rsp_addr3),
    .rsp_kind1    (rsp_kind1),
    .rsp_kind2    (rsp_kind2)
  );

  localparam logic [31:0] PC_A  = 32'h4000_0020; // index 2
  localparam logic [31:0] PC_A2 = 32'h4000_00A0; // index 2, other tag
  localparam logic [31:0] PC_B  = 32'h0000_3050; // index 5
  localparam logic [31:0] PC_C  = 32'h0000_5070; // index 7
  localparam logic [31:0] PC_D  = 32'h0000_1010; // index 1

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic put_fill(input logic [31:0] pc, input logic pv, input logic [1:0] pk,
                          input logic [31:0] ta, input logic [31:0] na,
                          input logic sv, input logic [1:0] sk,
                          input logic nv, input logic [1:0] nk,
                          input logic [31:0] tt, input logic [31:0] tn,
                          input logic [31:0] nt, input logic [31:0] nn);
    fill_en = 1'b1;       fill_blk = pc[31:4];
    fill_p_vld = pv;      fill_p_kind = pk;
    fill_t_addr = ta;     fill_n_addr = na;
    fill_st_vld = sv;     fill_st_kind = sk;
    fill_sn_vld = nv;     fill_sn_kind = nk;
    fill_tt_addr = tt;    fill_tn_addr = tn;
    fill_nt_addr = nt;    fill_nn_addr = nn;
  endtask

  task automatic put_look(input logic [31:0] pc, input logic p, input logic s);
    fetch_vld = 1'b1; fetch_pc = pc; pred_p_tk = p; pred_s_tk = s;
  endtask

  task automatic do_fill_a(input logic nv);
    @(negedge clk);
    put_fill(PC_A, 1'b1, 2'd0, 32'h0000_8000, 32'h4000_0030, 1'b1, 2'd1, nv, 2'd2,
             32'h0000_9000, 32'h0000_8010, 32'h0000_7000, 32'h4000_0040);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Response is registered at the posedge between the two negedges.
  task automatic do_look(input logic [31:0] pc, input logic p, input logic s);
    @(negedge clk);
    put_look(pc, p, s);
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rsp_vld after reset", 32'(rsp_vld), 32'd0);
    chk("R1", "rsp_addr2 after reset", rsp_addr2, 32'd0);
    do_look(PC_A, 1'b1, 1'b1);
    chk("R1", "first lookup misses", 32'(rsp_hit), 32'd0);
    chk("R2", "response valid", 32'(rsp_vld), 32'd1);
  endtask

  task automatic t_miss;
    do_look(PC_B, 1'b1, 1'b0);
    chk("R3", "miss hit flag", 32'(rsp_hit), 32'd0);
    chk("R3", "miss sequential addr2", rsp_addr2, 32'h0000_3060);
    chk("R3", "miss addr3_vld", 32'(rsp_addr3_vld), 32'd0);
    chk("R3", "miss addr3", rsp_addr3, 32'd0);
  endtask

  task automatic t_idle;
    do_look(PC_D, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2", "idle rsp_vld", 32'(rsp_vld), 32'd0);
    chk("R2", "idle rsp_hit", 32'(rsp_hit), 32'd0);
  endtask

  task automatic t_paths;
    do_fill_a(1'b1);
    do_look(PC_A, 1'b1, 1'b1);
    chk("R5", "TT hit", 32'(rsp_hit), 32'd1);
    chk("R5", "TT addr2", rsp_addr2, 32'h0000_8000);
    chk("R6", "TT addr3", rsp_addr3, 32'h0000_9000);
    chk("R6", "TT addr3_vld", 32'(rsp_addr3_vld), 32'd1);
    chk("R9", "TT kind1", 32'(rsp_kind1), 32'd0);
    chk("R9", "TT kind2", 32'(rsp_kind2), 32'd1);
    do_look(PC_A, 1'b1, 1'b0);
    chk("R5", "TN addr2", rsp_addr2, 32'h0000_8000);
    chk("R6", "TN addr3", rsp_addr3, 32'h0000_8010);
    do_look(PC_A, 1'b0, 1'b1);
    chk("R5", "NT addr2", rsp_addr2, 32'h4000_0030);
    chk("R6", "NT addr3", rsp_addr3, 32'h0000_7000);
    chk("R9", "NT kind2", 32'(rsp_kind2), 32'd2);
    do_look(PC_A, 1'b0, 1'b0);
    chk("R6", "NN addr3", rsp_addr3, 32'h4000_0040);
  endtask

  task automatic t_sec_invalid;
    do_fill_a(1'b0);
    do_look(PC_A, 1'b0, 1'b1);
    chk("R7", "hit", 32'(rsp_hit), 32'd1);
    chk("R7", "addr2 still given", rsp_addr2, 32'h4000_0030);
    chk("R7", "addr3_vld cleared", 32'(rsp_addr3_vld), 32'd0);
    chk("R7", "addr3 zero", rsp_addr3, 32'd0);
    chk("R7", "kind2 zero", 32'(rsp_kind2), 32'd0);
    do_look(PC_A, 1'b1, 1'b0);
    chk("R7", "taken path still valid", rsp_addr3, 32'h0000_8010);
  endtask

  task automatic t_no_branch;
    @(negedge clk);
    put_fill(PC_B, 1'b0, 2'd3, 32'h0000_AAA0, 32'h0000_3060, 1'b1, 2'd1, 1'b1, 2'd1,
             32'h1, 32'h2, 32'h3, 32'h4);
    @(negedge clk);
    fill_en = 1'b0;
    do_look(PC_B, 1'b1, 1'b1);
    chk("R8", "hit", 32'(rsp_hit), 32'd1);
    chk("R8", "addr2 is not-taken addr", rsp_addr2, 32'h0000_3060);
    chk("R8", "addr3_vld", 32'(rsp_addr3_vld), 32'd0);
    chk("R8", "kind1", 32'(rsp_kind1), 32'd0);
  endtask

  task automatic t_alias;
    do_look(PC_A2, 1'b1, 1'b1);
    chk("R4", "alias misses", 32'(rsp_hit), 32'd0);
    chk("R4", "alias sequential", rsp_addr2, 32'h4000_00B0);
    @(negedge clk);
    put_fill(PC_A2, 1'b1, 2'd2, 32'h0000_1230, 32'h4000_00B0, 1'b1, 2'd0, 1'b0, 2'd0,
             32'h0000_4560, 32'h0, 32'h0, 32'h0);
    @(negedge clk);
    fill_en = 1'b0;
    do_look(PC_A2, 1'b1, 1'b1);
    chk("R11", "new tag hits", 32'(rsp_hit), 32'd1);
    chk("R11", "new addr3", rsp_addr3, 32'h0000_4560);
    do_look(PC_A, 1'b1, 1'b1);
    chk("R11", "evicted tag misses", 32'(rsp_hit), 32'd0);
    chk("R11", "evicted sequential", rsp_addr2, 32'h4000_0030);
  endtask

  task automatic t_forward;
    @(negedge clk);
    put_fill(PC_C, 1'b1, 2'd1, 32'h0000_C000, 32'h0000_5080, 1'b1, 2'd3, 1'b0, 2'd0,
             32'h0000_C100, 32'h0, 32'h0, 32'h0);
    put_look(PC_C, 1'b1, 1'b1);
    @(negedge clk);
    fill_en = 1'b0; fetch_vld = 1'b0;
    chk("R10", "same-cycle fill hit", 32'(rsp_hit), 32'd1);
    chk("R10", "same-cycle addr2", rsp_addr2, 32'h0000_C000);
    chk("R10", "same-cycle addr3", rsp_addr3, 32'h0000_C100);
    chk("R10", "same-cycle kind2", 32'(rsp_kind2), 32'd3);
    @(negedge clk);
    put_fill(PC_D, 1'b1, 2'd0, 32'h0000_D000, 32'h0000_1020, 1'b0, 2'd0, 1'b0, 2'd0,
             32'h0, 32'h0, 32'h0, 32'h0);
    put_look(PC_B, 1'b0, 1'b0);
    @(negedge clk);
    fill_en = 1'b0; fetch_vld = 1'b0;
    chk("R10", "other index unaffected hit", 32'(rsp_hit), 32'd1);
    chk("R10", "other index addr2", rsp_addr2, 32'h0000_3060);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_miss;
    t_idle;
    t_paths;
    t_sec_invalid;
    t_no_branch;
    t_alias;
    t_forward;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule